// File: doc/BRIEF.md
# Framed Manchester Serial Encoder

This block turns a parallel data word of programmable length into a framed, Manchester-coded serial line. A frame has three parts. A start symbol comes first. The payload follows, with one to `DATA_W` bits. An optional stop field of one or two high bit periods ends the frame. Every payload bit is sent as two halves of equal length, and the level always changes at the middle of the bit. Because of that mid-bit change, a receiver can recover the bit clock from the line.

A frame is loaded through a ready/valid handshake. The block latches the word, the length and all frame options in the same cycle. Nothing on the inputs is looked at again until that frame ends. The half-bit period is timed by an internal divider with a programmable divisor. When no frame is in progress, the line rests high. A one-cycle done pulse marks the end of each frame. A new frame may be accepted in that same done cycle, so frames can run back to back.

Top module: `mfe_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_o` is 1, `busy_o` is 0, `done_o` is 0 and `ready_o` is 1.
- R2: With `conv_i`=0, a coded bit d drives the level d in its first half and the level ~d in its second half. A 1 is therefore high then low, which equals data XNOR bit clock.
- R3: With `conv_i`=1, a coded bit d drives ~d in its first half and d in its second half. A 1 is therefore low then high, which equals data XOR bit clock.
- R4: `len_i` holds the payload bit count minus one. A value of 0 sends one bit, and a value of 255 sends 256 bits.
- R5: With `msb_first_i`=0, the payload goes out from bit 0 upward to bit `len_i`. With `msb_first_i`=1, it goes out from bit `len_i` down to bit 0.
- R6: `start_mode_i` sets how the single start symbol is sent. A value of 0 sends it uncoded, low for both halves. A value of 1 or 3 codes it as a data 0 under the selected convention. A value of 2 codes it with the inverted mapping, so it comes out as a coded 1.
- R7: `stop_i` sets the stop field that follows the payload. A value of 0 sends no stop field, 1 sends one bit period held high, and 2 or 3 send two such periods.
- R8: Each half-bit lasts `div_i`+1 clock cycles. The first half of the start symbol appears in the cycle after the accepting edge. `busy_o` stays high for exactly (number of halves)×(`div_i`+1) cycles.
- R9: In the cycle after the last half, `done_o` is high for exactly one cycle. In that cycle `busy_o` is 0 and `line_o` is 1.
- R10: While busy, `ready_o` is 0. Any `valid_i` pulse and any change on the data, length, divisor or option inputs leave the current frame unchanged.
- R11: A `valid_i` presented in the done cycle is accepted, and the next frame's start symbol begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Frame request; accepted when ready_o is high |
| ready_o | output | 1 | High when a new frame can be accepted |
| data_i | input | DATA_W | Payload word |
| len_i | input | LEN_W | Payload bit count minus one |
| div_i | input | DIV_W | Half-bit length minus one, in clock cycles |
| conv_i | input | 1 | Coding convention: 0 selects XNOR, 1 selects XOR |
| start_mode_i | input | 2 | Start symbol handling: 0 uncoded, 1 or 3 coded, 2 inverted |
| msb_first_i | input | 1 | Payload order: 0 sends the LSB first, 1 sends the MSB first |
| stop_i | input | 2 | Stop field length: 0 none, 1 one bit, 2 or 3 two bits |
| line_o | output | 1 | Encoded serial line, high when idle |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after a frame ends |

## Verification
Two events can fall in the same cycle: the end-of-frame done pulse and the acceptance of the next frame. The bench drives `valid_i` for the following frame in the very cycle that `done_o` is observed. It then checks three things for that cycle: `done_o` is high, `ready_o` is high and the line is high. Finally, it checks that the new frame's waveform starts one cycle later with no extra idle cycle in between. Both directed and randomly chosen frames are chained this way.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  typedef enum logic [1:0] {
    FLD_IDLE  = 2'd0,
    FLD_START = 2'd1,
    FLD_DATA  = 2'd2,
    FLD_STOP  = 2'd3
  } field_e;

  localparam logic [1:0] SM_PLAIN  = 2'd0;
  localparam logic [1:0] SM_CODED  = 2'd1;
  localparam logic [1:0] SM_INVERT = 2'd2;
endpackage

// File: rtl/mfe_half_timer.sv
module mfe_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign half_end_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || !run_i)   cnt_q <= '0;
    else if (half_end_o)          cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i)); // R8
endmodule

// File: rtl/mfe_sequencer.sv
module mfe_sequencer
  import mfe_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              half_end_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              conv_i,
  input  logic [1:0]        start_mode_i,
  input  logic              msb_first_i,
  input  logic [1:0]        stop_i,
  output field_e            field_o,
  output logic              half_o,
  output logic              bit_o,
  output logic              conv_o,
  output logic [1:0]        start_mode_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              done_o
);
  field_e            field_q;
  logic              half_q;
  logic [LEN_W-1:0]  idx_q;
  logic              stop_cnt_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  div_q;
  logic              conv_q;
  logic [1:0]        smode_q;
  logic              msb_q;
  logic [1:0]        stop_q;

  logic [LEN_W-1:0]  sel;
  logic              last_bit;
  logic              last_stop;

  assign sel       = msb_q ? (len_q - idx_q) : idx_q;
  assign last_bit  = (idx_q == len_q);
  assign last_stop = (stop_q == 2'd1) || stop_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q    <= FLD_IDLE;
      half_q     <= 1'b0;
      idx_q      <= '0;
      stop_cnt_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_i) begin
        field_q    <= FLD_START;
        half_q     <= 1'b0;
        idx_q      <= '0;
        stop_cnt_q <= 1'b0;
      end else if (half_end_i) begin
        if (!half_q) begin
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          unique case (field_q)
            FLD_START: begin
              field_q <= FLD_DATA;
              idx_q   <= '0;
            end
            FLD_DATA: begin
              if (!last_bit) begin
                idx_q <= idx_q + 1'b1;
              end else if (stop_q == 2'd0) begin
                field_q <= FLD_IDLE;
                done_q  <= 1'b1;
              end else begin
                field_q    <= FLD_STOP;
                stop_cnt_q <= 1'b0;
              end
            end
            FLD_STOP: begin
              if (last_stop) begin
                field_q <= FLD_IDLE;
                done_q  <= 1'b1;
              end else begin
                stop_cnt_q <= 1'b1;
              end
            end
            default: field_q <= FLD_IDLE;
          endcase
        end
      end
    end
  end

  // Frame configuration is captured once per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      len_q   <= '0;
      div_q   <= '0;
      conv_q  <= 1'b0;
      smode_q <= SM_PLAIN;
      msb_q   <= 1'b0;
      stop_q  <= 2'd0;
    end else if (accept_i) begin
      data_q  <= data_i;
      len_q   <= len_i;
      div_q   <= div_i;
      conv_q  <= conv_i;
      smode_q <= start_mode_i;
      msb_q   <= msb_first_i;
      stop_q  <= stop_i;
    end
  end

  assign field_o      = field_q;
  assign half_o       = half_q;
  assign bit_o        = data_q[sel];
  assign conv_o       = conv_q;
  assign start_mode_o = smode_q;
  assign div_o        = div_q;
  assign done_o       = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((field_q != FLD_IDLE) && ($past(field_q) != FLD_IDLE))
      |-> ($stable(len_q) && $stable(data_q) && $stable(div_q))); // R10
endmodule

// File: rtl/mfe_line_coder.sv
module mfe_line_coder
  import mfe_pkg::*;
(
  input  field_e     field_i,
  input  logic       half_i,
  input  logic       bit_i,
  input  logic       conv_i,
  input  logic [1:0] start_mode_i,
  output logic       level_o
);
  logic start_bit;

  assign start_bit = (start_mode_i == SM_INVERT);

  always_comb begin
    unique case (field_i)
      FLD_START: level_o = (start_mode_i == SM_PLAIN) ? 1'b0
                                                      : (start_bit ^ half_i ^ conv_i);
      FLD_DATA:  level_o = bit_i ^ half_i ^ conv_i;
      default:   level_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mfe_encoder.sv
module mfe_encoder
  import mfe_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              conv_i,
  input  logic [1:0]        start_mode_i,
  input  logic              msb_first_i,
  input  logic [1:0]        stop_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);
  field_e           field;
  logic             half;
  logic             cur_bit;
  logic             conv_l;
  logic [1:0]       smode_l;
  logic [DIV_W-1:0] div_l;
  logic             half_end;
  logic             accept;

  assign busy_o  = (field != FLD_IDLE);
  assign ready_o = !busy_o;
  assign accept  = valid_i && ready_o;

  mfe_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .run_i      (busy_o),
    .div_i      (div_l),
    .half_end_o (half_end)
  );

  mfe_sequencer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .half_end_i   (half_end),
    .data_i       (data_i),
    .len_i        (len_i),
    .div_i        (div_i),
    .conv_i       (conv_i),
    .start_mode_i (start_mode_i),
    .msb_first_i  (msb_first_i),
    .stop_i       (stop_i),
    .field_o      (field),
    .half_o       (half),
    .bit_o        (cur_bit),
    .conv_o       (conv_l),
    .start_mode_o (smode_l),
    .div_o        (div_l),
    .done_o       (done_o)
  );

  mfe_line_coder u_coder (
    .field_i      (field),
    .half_i       (half),
    .bit_i        (cur_bit),
    .conv_i       (conv_l),
    .start_mode_i (smode_l),
    .level_o      (line_o)
  );

  AST_MID_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((field == FLD_DATA) && !half && half_end) |=> (line_o != $past(line_o))); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && line_o && $past(busy_o))); // R9
  AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field == FLD_STOP) |-> line_o); // R7
endmodule

// File: tb/mfe_encoder_tb.sv
`timescale 1ns/1ps
module mfe_encoder_tb;
  localparam int DATA_W = 256;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic              ready;
  logic [DATA_W-1:0] data = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [DIV_W-1:0]  div = '0;
  logic              conv = 1'b0;
  logic [1:0]        smode = 2'd0;
  logic              msb = 1'b0;
  logic [1:0]        stop = 2'd0;
  logic              line, busy, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit exp_h [0:1023];
  int n_half;

  always #2.5 clk = ~clk;

  mfe_encoder #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .data_i(data), .len_i(len), .div_i(div), .conv_i(conv),
    .start_mode_i(smode), .msb_first_i(msb), .stop_i(stop),
    .line_o(line), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic push(input bit b);
    exp_h[n_half] = b;
    n_half++;
  endtask

  task automatic enc(input bit b, input bit cv);
    push(cv ? ~b : b);
    push(cv ? b : ~b);
  endtask

  task automatic build(input logic [DATA_W-1:0] d, input int ln, input bit cv,
                       input int sm, input bit mf, input int sp);
    n_half = 0;
    if (sm == 0) begin push(1'b0); push(1'b0); end
    else if (sm == 2) enc(1'b1, cv);
    else enc(1'b0, cv);
    for (int i = 0; i <= ln; i++) enc(d[mf ? (ln - i) : i], cv);
    for (int s = 0; s < ((sp == 0) ? 0 : (sp == 1) ? 1 : 2); s++) begin
      push(1'b1); push(1'b1);
    end
  endtask

  function automatic logic [DATA_W-1:0] rand_word();
    logic [DATA_W-1:0] w;
    for (int k = 0; k < DATA_W / 32; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  // Called at a negedge; on return the bench sits at the done negedge when stay=1
  task automatic run_frame(input logic [DATA_W-1:0] d, input int ln, input int dv,
                           input bit cv, input int sm, input bit mf, input int sp,
                           input bit inject, input bit stay);
    int total, bad_h, act_v;
    bit bad, busy_bad, inj_bad;
    build(d, ln, cv, sm, mf, sp);
    data = d; len = LEN_W'(ln); div = DIV_W'(dv); conv = cv;
    smode = 2'(sm); msb = mf; stop = 2'(sp); valid = 1'b1;
    chk(ready === 1'b1, "R11", "ready before accept", int'(ready), 1);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    total = n_half * (dv + 1);
    bad = 0; busy_bad = 0; inj_bad = 0; bad_h = 0; act_v = 0;
    for (int i = 0; i < total; i++) begin
      if (line !== exp_h[i / (dv + 1)] && !bad) begin
        bad = 1; bad_h = i / (dv + 1); act_v = int'(line);
      end
      if (busy !== 1'b1 || done !== 1'b0 || ready !== 1'b0) busy_bad = 1;
      if (inject && i == 1) begin
        valid = 1'b1; data = rand_word(); len = LEN_W'($urandom);
        div = DIV_W'($urandom); conv = ~cv; smode = 2'($urandom);
        msb = ~mf; stop = 2'($urandom);
      end
      if (inject && i == 2) valid = 1'b0;
      @(negedge clk);
    end
    if (bad) $display("  first mismatch at half %0d of %0d", bad_h, n_half);
    chk(!bad, "R2 R3 R4 R5 R6 R7", "line waveform", act_v,
        bad ? int'(exp_h[bad_h]) : act_v);
    chk(!busy_bad, "R8", "busy span", int'(busy_bad), 0);
    if (inject) chk(!bad && !busy_bad, "R10", "frame unaffected by mid-frame request",
                    int'(bad || busy_bad), 0);
    chk(done === 1'b1 && busy === 1'b0 && line === 1'b1, "R9", "done cycle",
        {29'd0, done, busy, line}, 3'b101);
    if (!stay) begin
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0 && line === 1'b1 && ready === 1'b1,
          "R1", "idle after done", {28'd0, done, busy, line, ready}, 4'b0011);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(negedge clk);
    chk(line === 1'b1 && busy === 1'b0 && done === 1'b0 && ready === 1'b1,
        "R1", "in reset", {28'd0, line, busy, done, ready}, 4'b1001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line === 1'b1 && busy === 1'b0 && done === 1'b0 && ready === 1'b1,
        "R1", "after reset", {28'd0, line, busy, done, ready}, 4'b1001);

    run_frame(256'hA5, 7, 1, 1'b0, 1, 1'b0, 1, 0, 0);        // R2
    run_frame(256'hA5, 7, 1, 1'b1, 1, 1'b0, 1, 0, 0);        // R3
    run_frame(256'h3C, 7, 0, 1'b0, 0, 1'b0, 1, 0, 0);        // R6 plain start
    run_frame(256'h3C, 7, 0, 1'b1, 2, 1'b0, 2, 0, 0);        // R6 inverted start
    run_frame(256'h3C, 7, 2, 1'b0, 3, 1'b0, 0, 0, 0);        // R6 mode 3
    run_frame(256'h9F1, 11, 0, 1'b0, 1, 1'b1, 1, 0, 0);      // R5 msb first
    run_frame(256'h1, 0, 0, 1'b0, 1, 1'b0, 0, 0, 0);         // R4 one bit
    run_frame(rand_word(), 255, 0, 1'b1, 2, 1'b1, 2, 0, 0);  // R4 full length
    run_frame(256'h5, 3, 0, 1'b0, 1, 1'b0, 3, 0, 0);         // R7 two stops
    run_frame(256'h6B, 7, 5, 1'b1, 1, 1'b0, 1, 0, 0);        // R8 long halves
    run_frame(256'hC3, 7, 1, 1'b0, 1, 1'b0, 1, 1, 0);        // R10
    run_frame(256'h12, 7, 0, 1'b0, 2, 1'b0, 0, 0, 1);        // R11 chain
    run_frame(256'h34, 7, 1, 1'b1, 0, 1'b1, 1, 0, 0);

    for (int n = 0; n < 40; n++) begin
      run_frame(rand_word(), int'($urandom_range(0, 63)), int'($urandom_range(0, 3)),
                1'($urandom), int'($urandom_range(0, 3)), 1'($urandom),
                int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    chk(busy === 1'b0 && line === 1'b1, "R1", "final idle", {30'd0, busy, line}, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule